// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block runs the transmit side of one serial channel's DMA. When a poll request arrives, it walks a ring of 8-byte descriptors held in system memory. It reads each descriptor through a simple 32-bit request/acknowledge memory port. Descriptors are gathered until the one flagged as the last segment. For every segment that carries data, the block issues a copy request (buffer address and byte count) to an external payload mover. After a segment's data has been taken, the block hands the descriptor back to software. When the frame is complete, it strobes the trimmed frame length toward the serializer and raises a one-cycle transmit-done event.

Two length encodings are supported, selected by `mode_i`. In mode 0 the length field is a plain byte count. In mode 1 the length is counted in 32-bit words, with an optional small subtraction. The two modes also differ in how the ring pointer wraps. A single poll pass sends a bounded number of frames and stops early at the first descriptor that software has not handed over.

Top module: `tx_ring_fetch`

## Requirements
- R1: A register write at offset 0x80 sets the ring start address and also reloads the current descriptor pointer. A write at offset 0x84 sets the ring end address. Reads at those two offsets return the stored values, and any other offset reads as zero.
- R2: A pulse on `poll_i` starts a pass only if the ring start is nonzero, `chan_active_i` is high and `tx_en_i` is high. Otherwise no memory access, copy request, send or event occurs. The same three conditions are checked again before each frame of the pass.
- R3: Descriptor layout is as follows. Word0, at the current pointer, holds owner in bit 31, first-segment in bit 30, last-segment in bit 29 and length in bits [15:0]. Word1, at pointer+4, is the buffer address. If the owner bit is clear on a frame's first descriptor, the pass ends without any send or event.
- R4: In mode 0 the segment byte count equals the length field. In mode 1 it equals the length field times four. When bit 20 is set, the value of bits [25:24] is subtracted from that product, and the result is floored at zero.
- R5: Each segment with a nonzero byte count produces exactly one copy request carrying word1 and the byte count. The request is held stable until `cpy_ready_i`. A zero-count segment produces no request, but the ring still advances past it.
- R6: A descriptor whose first-segment bit is clear gets word0 written to zero once its data has been taken. The frame's first descriptor gets word0 written to zero after the send decision and before the done event. All release writes carry zero data.
- R7: After the last-segment descriptor, the total is reduced by (4 − pad) mod 4, where pad is bits [23:22] of that descriptor, floored at zero. If the result is nonzero, `send_o` pulses for one cycle with `send_len_o` equal to the result. If the result is zero, no send occurs.
- R8: In mode 0 the pointer steps by 8 and is reset to the ring start when the stepped value equals the end address. In mode 1 the pointer is reset to start when it already equals the end address, and steps by 8 otherwise.
- R9: Every completed frame pulses `tx_irq_o` for exactly one cycle, including frames whose trimmed length is zero.
- R10: If a descriptor after the first in a frame has its owner bit clear, the frame is aborted. There is no send and no event, the first descriptor is not released, and the pass ends.
- R11: One pass completes at most 16 frames; the next poll resumes at the following descriptor.
- R12: A frame's gathered byte total is capped at 18000. Any copy request that would exceed the cap is shortened to the room left, and one with no room left is omitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Length and wrap convention select (0 or 1) |
| chan_active_i | input | 1 | Channel enabled by command |
| tx_en_i | input | 1 | Transmit direction enabled |
| poll_i | input | 1 | Start a ring scan pass |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register offset within channel space |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| cpy_valid_o | output | 1 | Copy request valid |
| cpy_addr_o | output | 32 | Copy source buffer address |
| cpy_len_o | output | 18 | Copy byte count |
| cpy_ready_i | input | 1 | Copy request accepted |
| send_o | output | 1 | Frame send strobe |
| send_len_o | output | 15 | Trimmed frame length |
| tx_irq_o | output | 1 | Transmit-done event pulse |
| busy_o | output | 1 | Pass in progress |

## Verification
Frames are built from single descriptors, from three-segment chains that include a zero-length middle segment, and from mode 1 word counts with subtraction. Together these separate the byte and word conventions, show that empty segments are skipped without stalling the ring, and show that the pad trim is taken from the last descriptor only. Two-slot rings in each mode are re-armed after the first pass. This reveals whether the pointer wrapped to the start and shows that the two wrap rules give different ring sizes for one end address. Further cases cover a twenty-frame ring, a mid-frame unowned descriptor and an oversized two-segment frame. They expose the per-pass frame cap, the abort path that leaves the first descriptor owned, and the 18000-byte clipping of the second copy.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CHK, ST_W0, ST_W1, ST_COPY, ST_CLR, ST_ADV, ST_SEND, ST_REL, ST_DONE
  } tx_state_e;

  localparam int OWN_BIT    = 31;
  localparam int FS_BIT     = 30;
  localparam int LS_BIT     = 29;
  localparam int SUB_EN_BIT = 20;
  localparam int PAD_LO     = 22;
  localparam int SUB_LO     = 24;
  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/tx_seg_len.sv
module tx_seg_len #(
  parameter int LEN_W = 16,
  parameter int SEG_W = LEN_W + 2
) (
  input  logic             mode_i,
  input  logic [31:0]      word0_i,
  output logic [SEG_W-1:0] seg_len_o
);
  import tx_ring_pkg::*;

  logic [SEG_W-1:0] raw_len;
  logic [SEG_W-1:0] words;
  logic [SEG_W-1:0] sub;

  assign raw_len = SEG_W'(word0_i[LEN_W-1:0]);
  assign words   = {word0_i[LEN_W-1:0], 2'b00};
  assign sub     = word0_i[SUB_EN_BIT] ? SEG_W'(word0_i[SUB_LO+1:SUB_LO]) : '0;

  always_comb begin
    if (!mode_i)           seg_len_o = raw_len;
    else if (words >= sub) seg_len_o = words - sub;
    else                   seg_len_o = '0;
  end
endmodule

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          mode_i,
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  output logic [AW-1:0] nxt_o
);
  import tx_ring_pkg::*;

  logic [AW-1:0] step;
  assign step = cur_i + AW'(DESC_BYTES);

  always_comb begin
    if (!mode_i) nxt_o = (step == end_i) ? start_i : step;
    else         nxt_o = (cur_i == end_i) ? start_i : step;
  end
endmodule

// File: rtl/tx_ring_regs.sv
module tx_ring_regs #(
  parameter int          AW        = 32,
  parameter int          REG_AW    = 8,
  parameter logic [7:0]  START_OFS = 8'h80,
  parameter logic [7:0]  END_OFS   = 8'h84
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [AW-1:0]     wdata_i,
  output logic [AW-1:0]     rdata_o,
  input  logic              adv_i,
  input  logic [AW-1:0]     nxt_i,
  output logic [AW-1:0]     start_o,
  output logic [AW-1:0]     end_o,
  output logic [AW-1:0]     cur_o
);
  logic wr_start, wr_end;
  assign wr_start = wr_i && (addr_i == REG_AW'(START_OFS));
  assign wr_end   = wr_i && (addr_i == REG_AW'(END_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      end_o   <= '0;
      cur_o   <= '0;
    end else begin
      if (wr_start) begin
        start_o <= wdata_i;
        cur_o   <= wdata_i;
      end else if (adv_i) begin
        cur_o   <= nxt_i;
      end
      if (wr_end) end_o <= wdata_i;
    end
  end

  always_comb begin
    if (addr_i == REG_AW'(START_OFS))    rdata_o = start_o;
    else if (addr_i == REG_AW'(END_OFS)) rdata_o = end_o;
    else                                 rdata_o = '0;
  end
endmodule

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch #(
  parameter int         LEN_W       = 16,
  parameter int         SEG_W       = LEN_W + 2,
  parameter int         MAX_FRAME   = 18000,
  parameter int         PASS_FRAMES = 16,
  parameter int         REG_AW      = 8,
  parameter logic [7:0] START_OFS   = 8'h80,
  parameter logic [7:0] END_OFS     = 8'h84,
  parameter int         TOT_W       = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              chan_active_i,
  input  logic              tx_en_i,
  input  logic              poll_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              cpy_valid_o,
  output logic [31:0]       cpy_addr_o,
  output logic [SEG_W-1:0]  cpy_len_o,
  input  logic              cpy_ready_i,
  output logic              send_o,
  output logic [TOT_W-1:0]  send_len_o,
  output logic              tx_irq_o,
  output logic              busy_o
);
  import tx_ring_pkg::*;

  localparam int AW    = 32;
  localparam int CNT_W = $clog2(PASS_FRAMES + 1);

  tx_state_e        state_q;
  logic [31:0]      w0_q, buf_q, first_q;
  logic [TOT_W-1:0] total_q;
  logic [CNT_W-1:0] frames_q;

  logic [AW-1:0]    ring_start, ring_end, ring_cur, ring_nxt;
  logic [SEG_W-1:0] seg_len, room, clip;
  logic [1:0]       trim;
  logic [TOT_W-1:0] trimmed;
  logic             adv, may_run, is_fs;

  tx_ring_regs #(
    .AW(AW), .REG_AW(REG_AW), .START_OFS(START_OFS), .END_OFS(END_OFS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .adv_i   (adv),
    .nxt_i   (ring_nxt),
    .start_o (ring_start),
    .end_o   (ring_end),
    .cur_o   (ring_cur)
  );

  tx_ring_ptr #(.AW(AW)) u_ptr (
    .mode_i  (mode_i),
    .cur_i   (ring_cur),
    .start_i (ring_start),
    .end_i   (ring_end),
    .nxt_o   (ring_nxt)
  );

  tx_seg_len #(.LEN_W(LEN_W), .SEG_W(SEG_W)) u_len (
    .mode_i    (mode_i),
    .word0_i   (w0_q),
    .seg_len_o (seg_len)
  );

  // clip segment to room left under the frame cap
  assign room = SEG_W'(MAX_FRAME) - SEG_W'(total_q);
  assign clip = (seg_len > room) ? room : seg_len;

  assign trim    = 2'd0 - w0_q[PAD_LO+1:PAD_LO];
  assign trimmed = (total_q > TOT_W'(trim)) ? total_q - TOT_W'(trim) : '0;

  assign is_fs   = w0_q[FS_BIT];
  assign may_run = (ring_start != '0) && chan_active_i && tx_en_i &&
                   (frames_q < CNT_W'(PASS_FRAMES));
  assign adv     = (state_q == ST_ADV);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ring_cur;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_W0:  mem_req_o = 1'b1;
      ST_W1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ring_cur + 32'd4;
      end
      ST_CLR: begin
        mem_req_o = !is_fs;
        mem_we_o  = !is_fs;
      end
      ST_REL: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = first_q;
      end
      default: ;
    endcase
  end

  assign cpy_valid_o = (state_q == ST_COPY) && (clip != '0);
  assign cpy_addr_o  = buf_q;
  assign cpy_len_o   = clip;
  assign send_o      = (state_q == ST_SEND) && (trimmed != '0);
  assign send_len_o  = trimmed;
  assign tx_irq_o    = (state_q == ST_DONE);
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      w0_q     <= '0;
      buf_q    <= '0;
      first_q  <= '0;
      total_q  <= '0;
      frames_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (poll_i) begin
          frames_q <= '0;
          state_q  <= ST_CHK;
        end
        ST_CHK: begin
          if (may_run) begin
            first_q <= ring_cur;
            total_q <= '0;
            state_q <= ST_W0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_W0: if (mem_ack_i) begin
          // unowned: end of pass at frame start, abort mid-frame
          if (!mem_rdata_i[OWN_BIT]) state_q <= ST_IDLE;
          else begin
            w0_q    <= mem_rdata_i;
            state_q <= ST_W1;
          end
        end
        ST_W1: if (mem_ack_i) begin
          buf_q   <= mem_rdata_i;
          state_q <= ST_COPY;
        end
        ST_COPY: begin
          if (clip == '0) state_q <= ST_CLR;
          else if (cpy_ready_i) begin
            total_q <= total_q + TOT_W'(clip);
            state_q <= ST_CLR;
          end
        end
        ST_CLR: if (is_fs || mem_ack_i) state_q <= ST_ADV;
        ST_ADV: state_q <= w0_q[LS_BIT] ? ST_SEND : ST_W0;
        ST_SEND: state_q <= ST_REL;
        ST_REL: if (mem_ack_i) state_q <= ST_DONE;
        ST_DONE: begin
          frames_q <= frames_q + 1'b1;
          state_q  <= ST_CHK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_fetch_chk.sv
module tx_ring_fetch_chk #(
  parameter int SEG_W       = 18,
  parameter int TOT_W       = 15,
  parameter int MAX_FRAME   = 18000,
  parameter int PASS_FRAMES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [31:0]      mem_wdata_o,
  input logic             cpy_valid_o,
  input logic [31:0]      cpy_addr_o,
  input logic [SEG_W-1:0] cpy_len_o,
  input logic             cpy_ready_i,
  input logic             send_o,
  input logic [TOT_W-1:0] send_len_o,
  input logic             tx_irq_o
);
  logic [15:0] irq_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_cnt <= '0;
    else if (!busy_o)  irq_cnt <= '0;
    else if (tx_irq_o) irq_cnt <= irq_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !cpy_valid_o && !send_o && !tx_irq_o); // R2
  AST_CPY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpy_valid_o && !cpy_ready_i |=> cpy_valid_o && $stable(cpy_addr_o) && $stable(cpy_len_o)); // R5
  AST_CPY_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpy_valid_o |-> cpy_len_o != '0); // R5
  AST_RELEASE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o == 32'd0); // R6
  AST_SEND_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> send_len_o != '0); // R7
  AST_SEND_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> send_len_o <= TOT_W'(MAX_FRAME)); // R12
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o); // R9
  AST_PASS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> irq_cnt < 16'(PASS_FRAMES)); // R11
endmodule

bind tx_ring_fetch tx_ring_fetch_chk #(
  .SEG_W(SEG_W), .TOT_W(TOT_W), .MAX_FRAME(MAX_FRAME), .PASS_FRAMES(PASS_FRAMES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .cpy_valid_o (cpy_valid_o),
  .cpy_addr_o  (cpy_addr_o),
  .cpy_len_o   (cpy_len_o),
  .cpy_ready_i (cpy_ready_i),
  .send_o      (send_o),
  .send_len_o  (send_len_o),
  .tx_irq_o    (tx_irq_o)
);

// File: tb/tx_ring_fetch_tb.sv
module tx_ring_fetch_tb;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] FS  = 32'h4000_0000;
  localparam logic [31:0] LS  = 32'h2000_0000;
  localparam logic [31:0] SUBEN = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        mode = 1'b0, active = 1'b1, en = 1'b1, poll = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        cpy_valid, cpy_ready = 1'b1;
  logic [31:0] cpy_addr;
  logic [17:0] cpy_len;
  logic        send, irq, busy;
  logic [14:0] send_len;

  logic [31:0] mem [64];
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:2]];

  tx_ring_fetch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .chan_active_i(active),
    .tx_en_i(en), .poll_i(poll), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .cpy_valid_o(cpy_valid),
    .cpy_addr_o(cpy_addr), .cpy_len_o(cpy_len), .cpy_ready_i(cpy_ready),
    .send_o(send), .send_len_o(send_len), .tx_irq_o(irq), .busy_o(busy)
  );

  int n_tests = 0, n_fail = 0;
  int n_cpy, n_send, n_irq, n_mem;
  logic [31:0] cpy_a [32];
  int          cpy_l [32];
  int          last_send;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        n_mem++;
        if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
      end
      if (cpy_valid && cpy_ready) begin
        if (n_cpy < 32) begin
          cpy_a[n_cpy] = cpy_addr;
          cpy_l[n_cpy] = int'(cpy_len);
        end
        n_cpy++;
      end
      if (send) begin
        n_send++;
        last_send = int'(send_len);
      end
      if (irq) n_irq++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_log();
    n_cpy = 0; n_send = 0; n_irq = 0; n_mem = 0; last_send = -1;
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic set_desc(input int k, input logic [31:0] w0, input logic [31:0] b);
    mem[2*k]   = w0;
    mem[2*k+1] = b;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic setup(input logic m, input logic [31:0] s, input logic [31:0] e);
    mode = m;
    wr_reg(8'h80, s);
    wr_reg(8'h84, e);
    clr_log();
  endtask

  task automatic do_pass();
    @(negedge clk);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !send && !irq && !cpy_valid && !mem_req, "R2 reset quiet", busy, 0);
    reg_addr = 8'h80; #1;
    chk(reg_rdata == 0, "R1 reset start", reg_rdata, 0);
  endtask

  task automatic t_regs();
    wr_reg(8'h80, 32'h100);
    wr_reg(8'h84, 32'h140);
    reg_addr = 8'h80; #1; chk(reg_rdata == 32'h100, "R1 start rd", reg_rdata, 32'h100);
    reg_addr = 8'h84; #1; chk(reg_rdata == 32'h140, "R1 end rd", reg_rdata, 32'h140);
    reg_addr = 8'h88; #1; chk(reg_rdata == 0, "R1 other rd", reg_rdata, 0);
    reg_addr = 8'h00;
  endtask

  task automatic t_gate();
    clr_mem();
    setup(1'b0, 32'h100, 32'h140);
    set_desc(0, OWN | FS | LS | 32'd8, 32'hA000);
    en = 1'b0; do_pass(); en = 1'b1;
    chk(n_mem == 0 && n_send == 0, "R2 tx disabled", n_mem, 0);
    active = 1'b0; do_pass(); active = 1'b1;
    chk(n_mem == 0 && n_irq == 0, "R2 channel inactive", n_mem, 0);
    setup(1'b0, 32'h0, 32'h140);
    do_pass();
    chk(n_mem == 0 && n_send == 0, "R2 start zero", n_mem, 0);
  endtask

  task automatic t_m0_single();
    clr_mem();
    setup(1'b0, 32'h100, 32'h140);
    set_desc(0, OWN | FS | LS | 32'd100, 32'hA000);
    do_pass();
    chk(n_cpy == 1 && cpy_a[0] == 32'hA000 && cpy_l[0] == 100, "R5 single copy", cpy_l[0], 100);
    chk(n_send == 1 && last_send == 100, "R7 single send", last_send, 100);
    chk(n_irq == 1, "R9 single irq", n_irq, 1);
    chk(mem[0] == 0, "R6 first released", mem[0], 0);
    clr_log(); do_pass();
    chk(n_send == 0 && n_irq == 0, "R3 unowned ends pass", n_irq, 0);
  endtask

  task automatic t_m0_multi();
    clr_mem();
    setup(1'b0, 32'h100, 32'h140);
    set_desc(0, OWN | FS | 32'd10, 32'hB000);
    set_desc(1, OWN | 32'd0, 32'hB080);
    set_desc(2, OWN | LS | 32'h0080_0000 | 32'd20, 32'hB100);
    do_pass();
    chk(n_cpy == 2, "R5 zero-length skipped", n_cpy, 2);
    chk(cpy_a[1] == 32'hB100 && cpy_l[1] == 20, "R3 third segment copy", cpy_l[1], 20);
    chk(n_send == 1 && last_send == 28, "R7 pad2 trim", last_send, 28);
    chk(mem[0] == 0 && mem[2] == 0 && mem[4] == 0, "R6 all released", mem[2], 0);
  endtask

  task automatic t_m1_len();
    clr_mem();
    setup(1'b1, 32'h100, 32'h140);
    set_desc(0, OWN | FS | LS | SUBEN | 32'h0300_0000 | 32'h00C0_0000 | 32'd5, 32'hC000);
    do_pass();
    chk(n_cpy == 1 && cpy_l[0] == 17, "R4 mode1 words minus sub", cpy_l[0], 17);
    chk(last_send == 16, "R7 pad3 trim", last_send, 16);
    clr_log();
    set_desc(1, OWN | FS | LS | SUBEN | 32'h0200_0000, 32'hC100);
    do_pass();
    chk(n_cpy == 0 && n_send == 0 && n_irq == 1, "R4 floor zero, R9 irq w/o send", n_irq, 1);
  endtask

  task automatic t_wrap(input logic m, input logic [31:0] e, input int unit);
    clr_mem();
    setup(m, 32'h100, e);
    set_desc(0, OWN | FS | LS | 32'd4 / unit, 32'hD000);
    set_desc(1, OWN | FS | LS | 32'd4 / unit, 32'hD100);
    do_pass();
    chk(n_send == 2, "R8 two-slot ring", n_send, 2);
    clr_log();
    set_desc(0, OWN | FS | LS | 32'd12 / unit, 32'hD200);
    do_pass();
    chk(n_send == 1 && last_send == 12 && cpy_a[0] == 32'hD200, "R8 wrapped to start", last_send, 12);
  endtask

  task automatic t_abort();
    clr_mem();
    setup(1'b0, 32'h100, 32'h140);
    set_desc(0, OWN | FS | 32'd8, 32'hE000);
    set_desc(1, 32'd8 | LS, 32'hE100);
    do_pass();
    chk(n_cpy == 1 && n_send == 0 && n_irq == 0, "R10 abort no send", n_send, 0);
    chk(mem[0][31] == 1'b1, "R10 first kept owned", mem[0][31], 1);
  endtask

  task automatic t_limit();
    clr_mem();
    setup(1'b0, 32'h100, 32'h1A0);
    for (int k = 0; k < 20; k++) set_desc(k, OWN | FS | LS | 32'd1, 32'hF000 + k);
    do_pass();
    chk(n_send == 16 && n_irq == 16, "R11 pass capped", n_send, 16);
    clr_log(); do_pass();
    chk(n_send == 4 && cpy_a[0] == 32'hF010, "R11 resume", n_send, 4);
  endtask

  task automatic t_trunc();
    clr_mem();
    setup(1'b0, 32'h100, 32'h140);
    set_desc(0, OWN | FS | 32'd15000, 32'h1000);
    set_desc(1, OWN | LS | 32'd5000, 32'h2000);
    do_pass();
    chk(n_cpy == 2 && cpy_l[1] == 3000, "R12 copy clipped", cpy_l[1], 3000);
    chk(last_send == 18000, "R12 frame capped", last_send, 18000);
  endtask

  initial begin
    #3_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clr_mem(); clr_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_gate();
    t_m0_single();
    t_m0_multi();
    t_m1_len();
    t_wrap(1'b0, 32'h110, 1);
    t_wrap(1'b1, 32'h108, 4);
    t_abort();
    t_limit();
    t_trunc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule